// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by reading two translation entries from memory, one after the other. The logical address is split into a 10-bit first-level index (bits 31:22), a 10-bit second-level index (bits 21:12) and a 12-bit byte offset within a 4 KiB page. A root pointer, given with each request, gives the physical byte address of the first-level table for the current process.

Each walk makes one read of the first-level table. The entry that comes back names the frame that holds a second-level table page. A second read then fetches the entry that names the data frame. Each entry is a 32-bit word. Bit 0 is the valid flag and bits 31:12 hold the frame number. A clear valid flag at either level stops the walk with a fault. Reads go out on a request/grant port and come back on a response strobe, which can arrive any number of cycles later. The requester waits for `xlat_ready` before it presents an address. It then sees either a one-cycle done strobe carrying the physical address or a one-cycle fault strobe.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `xlat_ready` is 1 and `mem_req`, `xlat_done` and `xlat_fault` are 0. While `xlat_ready` is 1, no memory read is requested.
- R2: The first read of a walk goes to address `tbl_root + 4*va[31:22]`, as a 32-bit sum that wraps. The root and the address are both latched when the request is accepted.
- R3: The second read goes to `{E1[31:12], va[21:12], 2'b00}`, where E1 is the first-level entry. It is issued only when bit 0 of E1 is 1.
- R4: When bit 0 of the second-level entry E2 is 1, `xlat_done` pulses with `xlat_pa = {E2[31:12], va[11:0]}`.
- R5: When bit 0 of a fetched entry is 0, at either level, `xlat_fault` pulses, no further read is made, and `xlat_pa` reads 0.
- R6: `mem_req` stays high with a stable `mem_addr` until a cycle in which `mem_gnt` is 1. After that grant, `mem_req` is low until the response has arrived.
- R7: A `mem_rvalid` pulse that comes while no granted read is waiting for its data is ignored.
- R8: `xlat_done` and `xlat_fault` are never high together. Each lasts exactly one cycle, and `xlat_ready` is 1 in the following cycle.
- R9: A request is accepted only in a cycle where `xlat_ready` is 1. Requests made during a walk have no effect on that walk, and no effect afterwards.
- R10: Accepting a request drives `xlat_ready` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xlat_req | input | 1 | Translation request, taken when `xlat_ready` is 1 |
| xlat_va | input | 32 | Logical address to translate |
| tbl_root | input | 32 | Physical byte address of the first-level table |
| xlat_ready | output | 1 | Walker is idle and can take a request |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Byte address of the word to read |
| mem_gnt | input | 1 | Memory accepts the current read request |
| mem_rvalid | input | 1 | Read data is valid |
| mem_rdata | input | 32 | Read data word |
| xlat_done | output | 1 | One-cycle strobe: the translation succeeded |
| xlat_fault | output | 1 | One-cycle strobe: an entry was invalid |
| xlat_pa | output | 32 | Physical address, meaningful while `xlat_done` is 1 |

## Verification
Hashed table contents drive walks over random addresses. Entries that fail the valid test by chance, together with forced invalid entries at each level, tell a fault after the first read apart from a fault after the second. Fixed corner addresses check the field split at its extremes: an all-zero address, an all-ones address, and a root plus index sum that carries past a page or wraps at 2^32. Grant delays and response latencies are drawn at random and include the zero-wait case. Stray response strobes and stray requests during a walk would corrupt the resulting physical address if they were not ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_RD_OUTER = 3'd1,
      ST_WT_OUTER = 3'd2,
      ST_RD_INNER = 3'd3,
      ST_WT_INNER = 3'd4,
      ST_DONE     = 3'd5,
      ST_FAULT    = 3'd6
   } walk_state_e;

endpackage

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
   parameter int PTE_W     = 32,
   parameter int FRAME_LSB = 12,
   parameter int VALID_BIT = 0
) (
   input  logic [PTE_W-1:0]           entry,
   output logic                       ent_valid,
   output logic [PTE_W-FRAME_LSB-1:0] ent_frame
);
   localparam int FRAME_W = PTE_W - FRAME_LSB;

   if (VALID_BIT >= FRAME_LSB) begin : g_bad_valid
      $error("ptw_pte_decode: valid flag must sit below the frame field");
   end

   assign ent_valid = entry[VALID_BIT];
   assign ent_frame = entry[FRAME_LSB +: FRAME_W];

   logic unused_attr;
   assign unused_attr = ^entry[FRAME_LSB-1:0];
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int VA_W         = 32,
   parameter int PA_W         = 32,
   parameter int IDX_W        = 10,
   parameter int OFF_W        = 12,
   parameter int ENTRY_B      = 2,
   parameter bit ROOT_ALIGNED = 1'b0
) (
   input  logic [VA_W-1:0]       va,
   input  logic [PA_W-1:0]       root,
   input  logic [PA_W-OFF_W-1:0] inner_frame,
   input  logic                  sel_inner,
   output logic [PA_W-1:0]       addr
);
   localparam int P1_LSB = OFF_W + IDX_W;
   localparam int P2_LSB = OFF_W;

   logic [IDX_W-1:0] p1, p2;
   logic [PA_W-1:0]  outer_addr, inner_addr;

   assign p1 = va[P1_LSB +: IDX_W];
   assign p2 = va[P2_LSB +: IDX_W];

   if (ROOT_ALIGNED) begin : g_root_cat
      assign outer_addr = {root[PA_W-1:OFF_W], p1, {ENTRY_B{1'b0}}};
      logic unused_root_low;
      assign unused_root_low = ^root[OFF_W-1:0];
   end else begin : g_root_add
      assign outer_addr = root + PA_W'({p1, {ENTRY_B{1'b0}}});
   end

   assign inner_addr = {inner_frame, p2, {ENTRY_B{1'b0}}};
   assign addr       = sel_inner ? inner_addr : outer_addr;

   logic unused_va_off;
   assign unused_va_off = ^va[OFF_W-1:0];
endmodule

// File: rtl/ptw_seq.sv
module ptw_seq
   import ptw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic xlat_req,
   input  logic mem_gnt,
   input  logic mem_rvalid,
   input  logic ent_valid,
   output logic ready,
   output logic mem_req,
   output logic sel_inner,
   output logic ld_req,
   output logic ld_frame,
   output logic ld_pa,
   output logic done,
   output logic fault
);
   walk_state_e state_q, state_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      state_d   = state_q;
      ready     = 1'b0;
      mem_req   = 1'b0;
      sel_inner = 1'b0;
      ld_req    = 1'b0;
      ld_frame  = 1'b0;
      ld_pa     = 1'b0;
      done      = 1'b0;
      fault     = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            ready = 1'b1;
            if (xlat_req) begin
               ld_req  = 1'b1;
               state_d = ST_RD_OUTER;
            end
         end
         ST_RD_OUTER: begin
            mem_req = 1'b1;
            if (mem_gnt) state_d = ST_WT_OUTER;
         end
         ST_WT_OUTER: begin
            if (mem_rvalid) begin
               if (ent_valid) begin
                  ld_frame = 1'b1;
                  state_d  = ST_RD_INNER;
               end else begin
                  state_d  = ST_FAULT;
               end
            end
         end
         ST_RD_INNER: begin
            mem_req   = 1'b1;
            sel_inner = 1'b1;
            if (mem_gnt) state_d = ST_WT_INNER;
         end
         ST_WT_INNER: begin
            sel_inner = 1'b1;
            if (mem_rvalid) begin
               if (ent_valid) begin
                  ld_pa   = 1'b1;
                  state_d = ST_DONE;
               end else begin
                  state_d = ST_FAULT;
               end
            end
         end
         ST_DONE: begin
            done    = 1'b1;
            state_d = ST_IDLE;
         end
         ST_FAULT: begin
            fault   = 1'b1;
            state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
   parameter int VA_W         = 32,
   parameter int PA_W         = 32,
   parameter int PTE_W        = 32,
   parameter int IDX_W        = 10,
   parameter int OFF_W        = 12,
   parameter int VALID_BIT    = 0,
   parameter bit ROOT_ALIGNED = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            xlat_req,
   input  logic [VA_W-1:0] xlat_va,
   input  logic [PA_W-1:0] tbl_root,
   output logic            xlat_ready,
   output logic            mem_req,
   output logic [PA_W-1:0] mem_addr,
   input  logic            mem_gnt,
   input  logic            mem_rvalid,
   input  logic [PTE_W-1:0] mem_rdata,
   output logic            xlat_done,
   output logic            xlat_fault,
   output logic [PA_W-1:0] xlat_pa
);
   localparam int ENTRY_B = $clog2(PTE_W / 8);
   localparam int FRAME_W = PA_W - OFF_W;

   if (2 * IDX_W + OFF_W != VA_W) begin : g_bad_split
      $error("ptw_walker: two indices plus offset must cover the logical address");
   end
   if (IDX_W + ENTRY_B != OFF_W) begin : g_bad_table
      $error("ptw_walker: one table must fill exactly one page");
   end
   if (PTE_W - OFF_W != FRAME_W) begin : g_bad_frame
      $error("ptw_walker: entry frame field must match the physical frame width");
   end

   logic [VA_W-1:0]    va_q;
   logic [PA_W-1:0]    root_q;
   logic [FRAME_W-1:0] frame_q;
   logic [PA_W-1:0]    pa_q;

   logic ent_valid;
   logic [FRAME_W-1:0] ent_frame;
   logic sel_inner, ld_req, ld_frame, ld_pa, done_w;

   ptw_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .xlat_req   (xlat_req),
      .mem_gnt    (mem_gnt),
      .mem_rvalid (mem_rvalid),
      .ent_valid  (ent_valid),
      .ready      (xlat_ready),
      .mem_req    (mem_req),
      .sel_inner  (sel_inner),
      .ld_req     (ld_req),
      .ld_frame   (ld_frame),
      .ld_pa      (ld_pa),
      .done       (done_w),
      .fault      (xlat_fault)
   );

   ptw_pte_decode #(
      .PTE_W     (PTE_W),
      .FRAME_LSB (OFF_W),
      .VALID_BIT (VALID_BIT)
   ) u_dec (
      .entry     (mem_rdata),
      .ent_valid (ent_valid),
      .ent_frame (ent_frame)
   );

   ptw_addr_gen #(
      .VA_W         (VA_W),
      .PA_W         (PA_W),
      .IDX_W        (IDX_W),
      .OFF_W        (OFF_W),
      .ENTRY_B      (ENTRY_B),
      .ROOT_ALIGNED (ROOT_ALIGNED)
   ) u_agen (
      .va          (va_q),
      .root        (root_q),
      .inner_frame (frame_q),
      .sel_inner   (sel_inner),
      .addr        (mem_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         va_q    <= '0;
         root_q  <= '0;
         frame_q <= '0;
         pa_q    <= '0;
      end else begin
         if (ld_req) begin
            va_q   <= xlat_va;
            root_q <= tbl_root;
         end
         if (ld_frame) frame_q <= ent_frame;
         if (ld_pa)    pa_q    <= {ent_frame, va_q[OFF_W-1:0]};
      end
   end

   assign xlat_done = done_w;
   assign xlat_pa   = done_w ? pa_q : '0;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
   parameter int VA_W  = 32,
   parameter int PA_W  = 32,
   parameter int OFF_W = 12
) (
   input logic            clk,
   input logic            rst_n,
   input logic            xlat_req,
   input logic [VA_W-1:0] xlat_va,
   input logic            xlat_ready,
   input logic            mem_req,
   input logic [PA_W-1:0] mem_addr,
   input logic            mem_gnt,
   input logic            xlat_done,
   input logic            xlat_fault,
   input logic [PA_W-1:0] xlat_pa
);
   logic [OFF_W-1:0] off_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       off_seen <= '0;
      else if (xlat_ready && xlat_req)  off_seen <= xlat_va[OFF_W-1:0];
   end

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      xlat_ready |-> (!mem_req && !xlat_done && !xlat_fault));

   p_pa_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
      xlat_done |-> (xlat_pa[OFF_W-1:0] == off_seen));

   p_fault_nopa_r5: assert property (@(posedge clk) disable iff (!rst_n)
      xlat_fault |-> (xlat_pa == '0));

   p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

   p_req_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_gnt) |=> !mem_req);

   p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(xlat_done && xlat_fault));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      xlat_done |=> (!xlat_done && !xlat_fault && xlat_ready));

   p_fault_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      xlat_fault |=> (!xlat_fault && !xlat_done && xlat_ready));

   p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (xlat_ready && xlat_req) |=> !xlat_ready);
endmodule

bind ptw_walker ptw_walker_chk #(
   .VA_W  (VA_W),
   .PA_W  (PA_W),
   .OFF_W (OFF_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .xlat_req   (xlat_req),
   .xlat_va    (xlat_va),
   .xlat_ready (xlat_ready),
   .mem_req    (mem_req),
   .mem_addr   (mem_addr),
   .mem_gnt    (mem_gnt),
   .xlat_done  (xlat_done),
   .xlat_fault (xlat_fault),
   .xlat_pa    (xlat_pa)
);

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xlat_req = 1'b0;
   logic [31:0] xlat_va = '0;
   logic [31:0] tbl_root = '0;
   logic        xlat_ready;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_gnt = 1'b0;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        xlat_done;
   logic        xlat_fault;
   logic [31:0] xlat_pa;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   ptw_walker dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .xlat_req   (xlat_req),
      .xlat_va    (xlat_va),
      .tbl_root   (tbl_root),
      .xlat_ready (xlat_ready),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_gnt    (mem_gnt),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .xlat_done  (xlat_done),
      .xlat_fault (xlat_fault),
      .xlat_pa    (xlat_pa)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Table contents: a hash of the word address; fmode 1/2 clears the flag at level 0/1, fmode 3 forces it set.
   function automatic logic [31:0] pte_of(input logic [31:0] a, input int lvl, input int fmode);
      logic [31:0] h;
      logic [31:0] e;
      h = a * 32'h9E37_79B1;
      h = h ^ (h >> 15);
      e = {h[31:12], h[11:1], 1'b1};
      if (h[6:4] == 3'd0) e[0] = 1'b0;
      if (fmode == 1 && lvl == 0) e[0] = 1'b0;
      if (fmode == 2 && lvl == 1) e[0] = 1'b0;
      if (fmode == 3) e[0] = 1'b1;
      return e;
   endfunction

   task automatic run_walk(input logic [31:0] va, input logic [31:0] root, input int fmode, input bit fast);
      logic [31:0] a_out, a_in, e_out, e_in, exp_pa, want_addr;
      bit exp_fault;
      int exp_reads, nread, lat;
      bit got;
      a_out = root + {20'd0, va[31:22], 2'b00};
      e_out = pte_of(a_out, 0, fmode);
      a_in  = {e_out[31:12], va[21:12], 2'b00};
      e_in  = pte_of(a_in, 1, fmode);
      if (!e_out[0]) begin exp_fault = 1'b1; exp_reads = 1; exp_pa = '0; end
      else if (!e_in[0]) begin exp_fault = 1'b1; exp_reads = 2; exp_pa = '0; end
      else begin exp_fault = 1'b0; exp_reads = 2; exp_pa = {e_in[31:12], va[11:0]}; end

      check(xlat_ready == 1'b1, "R9 ready before request", {31'd0, xlat_ready}, 32'd1);
      xlat_va = va; tbl_root = root; xlat_req = 1'b1;
      @(posedge clk); #1;
      xlat_req = 1'b0; xlat_va = $urandom; tbl_root = $urandom;
      check(xlat_ready == 1'b0, "R10 ready drops after accept", {31'd0, xlat_ready}, 32'd0);
      nread = 0; got = 1'b0;
      for (int cyc = 0; cyc < 300 && !got; cyc++) begin
         if (xlat_done || xlat_fault) begin
            got = 1'b1;
         end else if (mem_req) begin
            want_addr = (nread == 0) ? a_out : a_in;
            check(nread < exp_reads, "R5 no read after invalid entry", nread, exp_reads);
            check(mem_addr == want_addr, (nread == 0) ? "R2 outer address" : "R3 inner address",
                  mem_addr, want_addr);
            mem_gnt = fast ? 1'b1 : 1'($urandom % 2);
            if (!fast && ($urandom % 4) == 0) xlat_req = 1'b1;
            if (!fast && ($urandom % 4) == 0) begin mem_rvalid = 1'b1; mem_rdata = $urandom | 32'd1; end
            @(posedge clk); #1;
            xlat_req = 1'b0; mem_rvalid = 1'b0;
            if (mem_gnt) begin
               mem_gnt = 1'b0;
               lat = fast ? 0 : int'($urandom % 4);
               for (int w = 0; w < lat; w++) begin
                  check(mem_req == 1'b0, "R6 no request while data pending", {31'd0, mem_req}, 32'd0);
                  @(posedge clk); #1;
               end
               mem_rvalid = 1'b1;
               mem_rdata  = (nread == 0) ? e_out : e_in;
               @(posedge clk); #1;
               mem_rvalid = 1'b0;
               nread++;
            end
         end else begin
            @(posedge clk); #1;
         end
      end
      check(got, "R8 walk completes", {31'd0, got}, 32'd1);
      if (exp_fault) begin
         check(xlat_fault == 1'b1 && xlat_done == 1'b0, "R5 fault strobe", {30'd0, xlat_done, xlat_fault}, 32'd1);
         check(xlat_pa == 32'd0, "R5 no address on fault", xlat_pa, 32'd0);
         check(nread == exp_reads, "R5 reads before fault", nread, exp_reads);
      end else begin
         check(xlat_done == 1'b1 && xlat_fault == 1'b0, "R4 done strobe", {30'd0, xlat_done, xlat_fault}, 32'd2);
         check(xlat_pa == exp_pa, "R4/R7/R9 physical address", xlat_pa, exp_pa);
      end
      @(posedge clk); #1;
      check(!xlat_done && !xlat_fault && xlat_ready, "R8 single-cycle strobe",
            {29'd0, xlat_ready, xlat_done, xlat_fault}, 32'd4);
      check(mem_req == 1'b0, "R1 idle after walk", {31'd0, mem_req}, 32'd0);
   endtask

   initial begin
      void'($urandom(32'd1357));
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(posedge clk); #1;
      check(xlat_ready == 1'b1, "R1 reset ready", {31'd0, xlat_ready}, 32'd1);
      check(mem_req == 1'b0, "R1 reset mem_req", {31'd0, mem_req}, 32'd0);
      check(xlat_done == 1'b0, "R1 reset done", {31'd0, xlat_done}, 32'd0);
      check(xlat_fault == 1'b0, "R1 reset fault", {31'd0, xlat_fault}, 32'd0);

      // stray response while idle (R7) must not start anything
      mem_rvalid = 1'b1; mem_rdata = 32'hFFFF_FFFF;
      @(posedge clk); #1;
      mem_rvalid = 1'b0;
      check(xlat_ready && !mem_req && !xlat_done && !xlat_fault, "R7 idle ignores response",
            {29'd0, xlat_ready, mem_req, xlat_done}, 32'd4);

      run_walk(32'h0000_0000, 32'h0010_0000, 3, 1'b1);
      run_walk(32'hFFFF_FFFF, 32'h0020_0000, 3, 1'b1);
      run_walk(32'hFFC0_0ABC, 32'h0000_1004, 3, 1'b0);
      run_walk(32'hFFC0_0123, 32'hFFFF_FFF8, 3, 1'b0);
      run_walk(32'h1234_5678, 32'h0003_0000, 1, 1'b0);
      run_walk(32'h8765_4321, 32'h0003_0000, 2, 1'b0);
      run_walk(32'h0040_1FFF, 32'h0008_0000, 2, 1'b1);
      for (int i = 0; i < 60; i++) begin
         run_walk($urandom, $urandom & 32'hFFFF_FFFC, 0, (i % 5) == 0);
      end

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL R8 watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule